// File: doc/BRIEF.md
# Register knock unlock detector

This block guards an add-on peripheral on a host CPU register bus. Out of reset it stays invisible: writes to the peripheral are dropped and reads give the same value an empty bus would give. Software wakes it with a knock. It writes 0x42 and then 0x52 back to back to the control register at page offset 0x31.

Once the knock completes, the block raises a sticky active flag that enables the rest of the peripheral's register file. From then on the control register behaves as a normal read/write register whose top bit always reads 0. A read therefore never shows 0xFF, and software takes any non-0xFF value to mean present and active. Software probes by reading the control register. If it sees 0xFF, it performs the knock.

Top module: `knock_unlock`

## Requirements
- R1: After reset (rst_ni low, asynchronous), active_o is 0 and a read of offset 0x31 returns 0xFF with rdrive_o at 0.
- R2: While active_o is 0, every read gives rdata_o = 0xFF and rdrive_o = 0, at any address.
- R3: Writes to offset 0x31 that do not complete the knock leave the control bits untouched. The first read after unlocking returns the reset value 0x00.
- R4: A write of 0x42 to offset 0x31, followed by a write of 0x52 to offset 0x31 with no other write to 0x31 between them, sets active_o from the clock edge that takes the 0x52. From then on a read of 0x31 drives rdrive_o = 1 with a value other than 0xFF.
- R5: A write to 0x31 of any value other than 0x42 or 0x52 after the 0x42 cancels the knock, so a following 0x52 does not unlock. A repeated 0x42 keeps the knock armed, so a following 0x52 still unlocks.
- R6: A write of 0x52 to 0x31 that does not follow an armed 0x42 has no effect.
- R7: Once set, active_o stays 1 until reset. Later writes to 0x31 store bits 6:0 of the written value. A read returns {0, stored bits 6:0}, and writing 0x42 or 0x52 again does not lock the block.
- R8: Writes and reads at any offset other than 0x31 neither advance nor cancel the knock.
- R9: A read at an offset other than 0x31 gives rdrive_o = 0 and rdata_o = 0xFF, even when active.
- R10: With re_i low, rdrive_o is 0 and rdata_o is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Register page offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, 0xFF when not driving |
| rdrive_o | output | 1 | Block drives the read data bus |
| active_o | output | 1 | Peripheral revealed; enables the rest of the register file |

## Verification
The read path is combinational. rdata_o and rdrive_o follow addr_i and re_i in the same cycle, so the bench applies each read at the falling edge and samples it 2 ns later, before the next rising edge. Writes take effect at the rising edge that samples we_i. The active flag and the stored control bits therefore show up in the step after the one that wrote them, and the vector table expects each write's effect one step later. Reset acts without a clock, so it is checked while rst_ni is still low.

// File: rtl/knock_pkg.sv
package knock_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } knock_st_e;
endpackage

// File: rtl/knock_seq_fsm.sv
module knock_seq_fsm
  import knock_pkg::*;
#(
  parameter int unsigned  DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY0 = 8'h42,
  parameter logic [DATA_W-1:0] KEY1 = 8'h52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              active_o,
  output logic              armed_o
);
  knock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (ctrl_wr_i) begin
      unique case (st_q)
        KS_LOCKED: if (wdata_i == KEY0) st_d = KS_ARMED;
        KS_ARMED: begin
          if (wdata_i == KEY1)      st_d = KS_OPEN;
          else if (wdata_i == KEY0) st_d = KS_ARMED;  // fresh first key
          else                      st_d = KS_LOCKED;
        end
        default: st_d = KS_OPEN;                     // sticky until reset
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KS_LOCKED;
    else         st_q <= st_d;
  end

  assign active_o = (st_q == KS_OPEN);
  assign armed_o  = (st_q == KS_ARMED);
endmodule

// File: rtl/knock_ctrl_reg.sv
module knock_ctrl_reg #(
  parameter int unsigned BITS_W = 7,
  parameter logic [BITS_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BITS_W-1:0] wdata_i,
  output logic [BITS_W-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bits_o <= RST_VAL;
    else if (wr_en_i) bits_o <= wdata_i;
  end
endmodule

// File: rtl/knock_rd_mux.sv
module knock_rd_mux #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] IDLE_VAL = 8'hFF
) (
  input  logic              active_i,
  input  logic              rd_hit_i,
  input  logic [DATA_W-2:0] bits_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdrive_o
);
  // top bit reads 0 so an active read never matches the idle pattern
  always_comb begin
    rdrive_o = active_i && rd_hit_i;
    rdata_o  = rdrive_o ? {1'b0, bits_i} : IDLE_VAL;
  end
endmodule

// File: rtl/knock_unlock.sv
module knock_unlock #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h31,
  parameter logic [DATA_W-1:0] KEY0 = 8'h42,
  parameter logic [DATA_W-1:0] KEY1 = 8'h52,
  parameter logic [DATA_W-1:0] IDLE_VAL = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdrive_o,
  output logic              active_o
);
  localparam int unsigned BITS_W = DATA_W - 1;

  logic              ctrl_hit;
  logic              ctrl_wr;
  logic              key_armed;
  logic [BITS_W-1:0] ctrl_bits;

  assign ctrl_hit = (addr_i == CTRL_ADDR);
  assign ctrl_wr  = we_i && ctrl_hit;

  knock_seq_fsm #(
    .DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_wr_i(ctrl_wr),
    .wdata_i  (wdata_i),
    .active_o (active_o),
    .armed_o  (key_armed)
  );

  knock_ctrl_reg #(
    .BITS_W(BITS_W), .RST_VAL('0)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(ctrl_wr && active_o),
    .wdata_i(wdata_i[BITS_W-1:0]),
    .bits_o (ctrl_bits)
  );

  knock_rd_mux #(
    .DATA_W(DATA_W), .IDLE_VAL(IDLE_VAL)
  ) u_rd (
    .active_i(active_o),
    .rd_hit_i(re_i && ctrl_hit),
    .bits_i  (ctrl_bits),
    .rdata_o (rdata_o),
    .rdrive_o(rdrive_o)
  );
endmodule

// File: rtl/knock_unlock_chk.sv
module knock_unlock_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h31,
  parameter logic [DATA_W-1:0] KEY0 = 8'h42,
  parameter logic [DATA_W-1:0] KEY1 = 8'h52,
  parameter logic [DATA_W-1:0] IDLE_VAL = 8'hFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdrive_o,
  input logic              active_o,
  input logic              armed_i
);
  AST_LOCKED_IDLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (rdata_o == IDLE_VAL && !rdrive_o)); // R2
  AST_STICKY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> active_o); // R7
  AST_UNLOCK_ON_KEY1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(we_i && addr_i == CTRL_ADDR && wdata_i == KEY1 && armed_i)); // R4
  AST_ARM_ON_KEY0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_i) |-> $past(we_i && addr_i == CTRL_ADDR && wdata_i == KEY0)); // R5
  AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == CTRL_ADDR) |=> ($stable(armed_i) && $stable(active_o))); // R8
  AST_DRIVE_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdrive_o |-> (rdata_o != IDLE_VAL)); // R4
  AST_OFF_ADDR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != CTRL_ADDR || !re_i) |-> (!rdrive_o && rdata_o == IDLE_VAL)); // R9 R10
endmodule

bind knock_unlock knock_unlock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
  .KEY0(KEY0), .KEY1(KEY1), .IDLE_VAL(IDLE_VAL)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .rdrive_o(rdrive_o),
  .active_o(active_o),
  .armed_i (key_armed)
);

// File: tb/knock_unlock_tb_top.sv
module knock_unlock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;
  logic       rdrive;
  logic       active;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  knock_unlock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .rdrive_o(rdrive), .active_o(active)
  );

  // {req[3:0], op[1:0] (0 idle,1 write,2 read), addr[5:0], data[7:0], act, drv, rdata[7:0]}
  localparam int NV = 22;
  localparam logic [29:0] VEC [NV] = '{
    {4'd1,  2'd0, 6'h31, 8'h00, 1'b0, 1'b0, 8'hFF}, // R1
    {4'd2,  2'd2, 6'h31, 8'h00, 1'b0, 1'b0, 8'hFF}, // R2
    {4'd3,  2'd1, 6'h31, 8'h05, 1'b0, 1'b0, 8'hFF}, // R3 locked write
    {4'd6,  2'd1, 6'h31, 8'h52, 1'b0, 1'b0, 8'hFF}, // R6 lone second key
    {4'd6,  2'd2, 6'h31, 8'h00, 1'b0, 1'b0, 8'hFF}, // R6
    {4'd5,  2'd1, 6'h31, 8'h42, 1'b0, 1'b0, 8'hFF}, // R5
    {4'd5,  2'd1, 6'h31, 8'h10, 1'b0, 1'b0, 8'hFF}, // R5 cancels
    {4'd5,  2'd1, 6'h31, 8'h52, 1'b0, 1'b0, 8'hFF}, // R5
    {4'd5,  2'd2, 6'h31, 8'h00, 1'b0, 1'b0, 8'hFF}, // R5 still locked
    {4'd8,  2'd1, 6'h31, 8'h42, 1'b0, 1'b0, 8'hFF}, // R8
    {4'd8,  2'd1, 6'h30, 8'h99, 1'b0, 1'b0, 8'hFF}, // R8 foreign write
    {4'd8,  2'd2, 6'h32, 8'h00, 1'b0, 1'b0, 8'hFF}, // R8 foreign read
    {4'd8,  2'd1, 6'h31, 8'h52, 1'b0, 1'b0, 8'hFF}, // R8 completes knock
    {4'd3,  2'd2, 6'h31, 8'h00, 1'b1, 1'b1, 8'h00}, // R3 reset value kept
    {4'd4,  2'd2, 6'h31, 8'h00, 1'b1, 1'b1, 8'h00}, // R4
    {4'd9,  2'd2, 6'h30, 8'h00, 1'b1, 1'b0, 8'hFF}, // R9
    {4'd10, 2'd0, 6'h31, 8'h00, 1'b1, 1'b0, 8'hFF}, // R10
    {4'd7,  2'd1, 6'h31, 8'hFF, 1'b1, 1'b0, 8'hFF}, // R7
    {4'd7,  2'd2, 6'h31, 8'h00, 1'b1, 1'b1, 8'h7F}, // R7 top bit reads 0
    {4'd7,  2'd1, 6'h31, 8'h42, 1'b1, 1'b0, 8'hFF}, // R7
    {4'd7,  2'd1, 6'h31, 8'h52, 1'b1, 1'b0, 8'hFF}, // R7 no relock
    {4'd7,  2'd2, 6'h31, 8'h00, 1'b1, 1'b1, 8'h52}  // R7
  };

  task automatic check(input int req, input logic a, input logic d, input logic [7:0] r);
    n_chk++;
    if (active !== a || rdrive !== d || rdata !== r) begin
      n_fail++;
      $display("FAIL R%0d: act/drv/rdata actual %b/%b/%02h expected %b/%b/%02h",
               req, active, rdrive, rdata, a, d, r);
    end
  endtask

  // apply at falling edge, sample 2 ns later; writes land at the next rising edge
  task automatic step(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = (op == 2'd1); re = (op == 2'd2);
    #2;
  endtask

  initial begin
    #40 rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][25:24], VEC[i][23:18], VEC[i][17:10]);
      check(int'(VEC[i][29:26]), VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end
    // R1: asynchronous reset from active
    step(2'd2, 6'h31, 8'h00);
    rst_n = 1'b0;
    #1 check(1, 1'b0, 1'b0, 8'hFF);
    @(negedge clk) rst_n = 1'b1;
    step(2'd2, 6'h31, 8'h00);
    check(1, 1'b0, 1'b0, 8'hFF);
    // R5: repeated first key keeps the knock armed
    step(2'd1, 6'h31, 8'h42);
    step(2'd1, 6'h31, 8'h42);
    step(2'd1, 6'h31, 8'h52);
    step(2'd2, 6'h31, 8'h00);
    check(5, 1'b1, 1'b1, 8'h00);
    // R10: read strobe low while active
    step(2'd0, 6'h31, 8'h00);
    check(10, 1'b1, 1'b0, 8'hFF);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL R0: watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule